// File: doc/BRIEF.md
# Configuration Save/Restore Sequencer

This block sits behind an I2C target front end that has already turned the bus into events: START, STOP and whole received bytes. It watches each transfer and decides whether to acknowledge each byte. It recognises a two-byte write made of the device address followed by a command byte, and after the STOP that closes such a transfer it runs one of two operations. A save copies the 96-bit configuration register set into a register-backed non-volatile store. A restore copies the store back into the configuration registers.

Each operation lasts a fixed number of clock cycles, given by a parameter, and the save is the longer of the two. While an operation runs, the block acknowledges nothing, not even its own address. When it finishes, it pulses `done` and answers its address again. After reset the block restores the store on its own. This power-up restore waits for the power input to be high, but it does not look at the PLL hold input or at configuration bit 57. Until the power-up restore finishes, every configuration bit reads 0.

A user-issued operation is accepted only if, when STOP arrives, the power input is high, the PLL hold input is low and configuration bit 57 is 0. If any of these fails, the command is dropped: the registers and the store stay as they were and the block stays idle.

Top module: `cfg_persist_seq`

## Requirements
- R1: After reset, `busy` is 1 and `cfg_q` is all zero. When the power-up restore ends, `cfg_q` equals the stored contents (parameter STORE_INIT when nothing has been saved since reset), `busy` falls, and `done` is high for exactly one cycle.
- R2: The power-up restore counts only cycles in which `pwr_on` is 1, and it lasts BOOT_CYCLES such cycles whatever the values of `pll_hold` and `cfg_q[57]`.
- R3: When idle, the first byte after START is acknowledged if bits 7:1 equal DEV_ADDR, with bit 0 as R/W (0 = write, 1 = read) and either value accepted. A first byte with any other address is not acknowledged.
- R4: Later bytes of the same transfer are acknowledged only in a write transfer to DEV_ADDR.
- R5: Command byte SAVE_CODE selects save and RESTORE_CODE selects restore. The operation does not start when the command byte arrives. `busy` rises in the cycle after STOP is sampled and stays high for SAVE_CYCLES or RESTORE_CYCLES cycles.
- R6: While `busy` is 1, no byte is acknowledged, including an address byte that matches DEV_ADDR.
- R7: A save writes `cfg_q` into the store at its last cycle. A restore loads the store into `cfg_q` at its last cycle. `done` is high for the single cycle after `busy` falls.
- R8: A user command runs only if, at STOP, `pwr_on`=1, `pll_hold`=0 and `cfg_q[57]`=0. Otherwise `busy` stays 0 and neither `cfg_q` nor the store changes.
- R9: No operation runs when the command code is unknown, when the transfer has one byte or three or more bytes before STOP, or when it is a read.
- R10: `cfg_load` writes `cfg_load_data` into `cfg_q` only while `busy` is 0, and has no effect while `busy` is 1.
- R11: After an operation completes, the device address is acknowledged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| ev_start | input | 1 | START condition seen (one-cycle pulse) |
| ev_stop | input | 1 | STOP condition seen (one-cycle pulse) |
| ev_byte_valid | input | 1 | A complete byte was received |
| ev_byte | input | 8 | Received byte |
| ack | output | 1 | Acknowledge the byte offered this cycle |
| pwr_on | input | 1 | High when the device is not powered down |
| pll_hold | input | 1 | High when the PLL is not enabled |
| cfg_load | input | 1 | Normal programming write into the configuration registers |
| cfg_load_data | input | 96 | Data for `cfg_load` |
| cfg_q | output | 96 | Configuration register contents |
| busy | output | 1 | An operation is running |
| done | output | 1 | One-cycle pulse after an operation ends |

## Verification
A wrong operation code, or a busy counter that stops at the wrong value, shows on `busy`. Its length, counted in cycles after STOP, differs from the expected count, and the bench sees this no later than the cycle in which the operation should end. A store that was written wrongly, or not written, stays hidden until the next restore brings it into `cfg_q`, so the bench follows every save with a restore after fresh data has been loaded over the registers. A frame tracker left in a stale state shows up on `ack` at the next byte, and in `busy` staying low, or rising, after the next STOP.

// File: rtl/cfg_persist_pkg.sv
package cfg_persist_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_SAVE, OP_RESTORE, OP_BOOT} op_e;

  // map a command byte to an operation
  function automatic op_e decode_cmd(input logic [7:0] code,
                                     input logic [7:0] save_code,
                                     input logic [7:0] rest_code);
    if (code == save_code) return OP_SAVE;
    if (code == rest_code) return OP_RESTORE;
    return OP_NONE;
  endfunction

  // user interlock: powered, PLL enabled, lock bit clear
  function automatic logic user_ok(input logic pwr, input logic hold, input logic lock);
    return pwr & ~hold & ~lock;
  endfunction

  // duration in cycles for an operation
  function automatic logic [31:0] op_len(input op_e op, input logic [31:0] s_len,
                                         input logic [31:0] r_len, input logic [31:0] b_len);
    case (op)
      OP_SAVE:    return s_len;
      OP_RESTORE: return r_len;
      default:    return b_len;
    endcase
  endfunction
endpackage

// File: rtl/cfg_persist_frame.sv
module cfg_persist_frame
  import cfg_persist_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'h6A,
  parameter logic [7:0] SAVE_CODE    = 8'hA5,
  parameter logic [7:0] RESTORE_CODE = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_byte_valid,
  input  logic [7:0] ev_byte,
  output logic       ack,
  output op_e        req_op
);
  logic       in_frame, addr_hit, wr_frame;
  logic [1:0] nbytes;
  logic [7:0] cmd_q;
  logic       addr_match;

  assign addr_match = (ev_byte[7:1] == DEV_ADDR);

  always_comb begin
    ack = 1'b0;
    if (ev_byte_valid && in_frame && !busy)
      ack = (nbytes == 2'd0) ? addr_match : (addr_hit & wr_frame);
  end

  always_comb begin
    req_op = OP_NONE;
    if (ev_stop && in_frame && !busy && addr_hit && wr_frame && nbytes == 2'd2)
      req_op = decode_cmd(cmd_q, SAVE_CODE, RESTORE_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      addr_hit <= 1'b0;
      wr_frame <= 1'b0;
      nbytes   <= 2'd0;
      cmd_q    <= 8'h00;
    end else if (busy) begin
      in_frame <= 1'b0;
      addr_hit <= 1'b0;
      nbytes   <= 2'd0;
    end else if (ev_start) begin
      in_frame <= 1'b1;
      addr_hit <= 1'b0;
      wr_frame <= 1'b0;
      nbytes   <= 2'd0;
    end else if (ev_stop) begin
      in_frame <= 1'b0;
    end else if (ev_byte_valid && in_frame) begin
      if (nbytes == 2'd0) begin
        addr_hit <= addr_match;
        wr_frame <= ~ev_byte[0];
      end
      if (nbytes == 2'd1) cmd_q <= ev_byte;
      if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
    end
  end

  // R9
  short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && nbytes != 2'd2) |-> req_op == OP_NONE);
endmodule

// File: rtl/cfg_persist_timer.sv
module cfg_persist_timer #(
  parameter int CW       = 8,
  parameter int BOOT_LEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          run,
  output logic          busy,
  output logic          fin
);
  logic [CW-1:0] cnt;

  assign fin = busy & run & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      cnt  <= CW'(BOOT_LEN - 1);
    end else if (load && !busy) begin
      busy <= 1'b1;
      cnt  <= len - CW'(1);
    end else if (busy && run) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  // R7
  fin_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
  // R2
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !run) |=> (busy && $stable(cnt)));
endmodule

// File: rtl/cfg_persist_store.sv
module cfg_persist_store #(
  parameter int         W         = 96,
  parameter logic [W-1:0] STORE_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  input  logic         save_fin,
  input  logic         rest_fin,
  output logic [W-1:0] cfg_q
);
  logic [W-1:0] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      store_q <= STORE_INIT;
    end else begin
      if (rest_fin)                cfg_q <= store_q;
      else if (load_en && !busy)   cfg_q <= load_data;
      if (save_fin)                store_q <= cfg_q;
    end
  end

  // R7
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !save_fin |=> $stable(store_q));
endmodule

// File: rtl/cfg_persist_seq.sv
module cfg_persist_seq
  import cfg_persist_pkg::*;
#(
  parameter int         W            = 96,
  parameter int         LOCK_BIT     = 57,
  parameter logic [6:0] DEV_ADDR     = 7'h6A,
  parameter logic [7:0] SAVE_CODE    = 8'hA5,
  parameter logic [7:0] RESTORE_CODE = 8'h5A,
  parameter int         SAVE_CYCLES    = 64,
  parameter int         RESTORE_CYCLES = 24,
  parameter int         BOOT_CYCLES    = 32,
  parameter logic [W-1:0] STORE_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_start,
  input  logic         ev_stop,
  input  logic         ev_byte_valid,
  input  logic [7:0]   ev_byte,
  output logic         ack,
  input  logic         pwr_on,
  input  logic         pll_hold,
  input  logic         cfg_load,
  input  logic [W-1:0] cfg_load_data,
  output logic [W-1:0] cfg_q,
  output logic         busy,
  output logic         done
);
  localparam int MAXC = (SAVE_CYCLES > RESTORE_CYCLES) ?
                        ((SAVE_CYCLES > BOOT_CYCLES) ? SAVE_CYCLES : BOOT_CYCLES) :
                        ((RESTORE_CYCLES > BOOT_CYCLES) ? RESTORE_CYCLES : BOOT_CYCLES);
  localparam int CW = $clog2(MAXC + 1);

  op_e           req_op, op_q;
  logic          go, fin, run, save_fin, rest_fin, boot_done_q;
  logic [CW-1:0] len;

  cfg_persist_frame #(.DEV_ADDR(DEV_ADDR), .SAVE_CODE(SAVE_CODE),
                      .RESTORE_CODE(RESTORE_CODE)) u_frame (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte_valid(ev_byte_valid), .ev_byte(ev_byte), .ack(ack), .req_op(req_op));

  assign go  = (req_op != OP_NONE) && user_ok(pwr_on, pll_hold, cfg_q[LOCK_BIT]);
  assign len = CW'(op_len(req_op, SAVE_CYCLES, RESTORE_CYCLES, BOOT_CYCLES));
  assign run = (op_q != OP_BOOT) | pwr_on;

  cfg_persist_timer #(.CW(CW), .BOOT_LEN(BOOT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(go), .len(len), .run(run), .busy(busy), .fin(fin));

  assign save_fin = fin && (op_q == OP_SAVE);
  assign rest_fin = fin && (op_q == OP_RESTORE || op_q == OP_BOOT);

  cfg_persist_store #(.W(W), .STORE_INIT(STORE_INIT)) u_store (
    .clk(clk), .rst_n(rst_n), .busy(busy), .load_en(cfg_load), .load_data(cfg_load_data),
    .save_fin(save_fin), .rest_fin(rest_fin), .cfg_q(cfg_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q        <= OP_BOOT;
      done        <= 1'b0;
      boot_done_q <= 1'b0;
    end else begin
      if (go) op_q <= req_op;
      done <= fin;
      if (fin) boot_done_q <= 1'b1;
    end
  end

  // R1
  boot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done_q |-> cfg_q == '0);
  // R5
  start_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_stop));
  // R6
  quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ack);
  // R8
  blocked_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op != OP_NONE && !go) |=> !busy);
  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> $stable(cfg_q));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/cfg_persist_seq_bench.sv
`timescale 1ns/1ps
module cfg_persist_seq_bench;
  localparam int W = 96;
  localparam logic [6:0] DEV = 7'h6A;
  localparam logic [7:0] CS = 8'hA5, CR = 8'h5A;
  localparam int SC = 20, RC = 8, BC = 12;
  localparam logic [W-1:0] INIT = 96'h0123_4567_89AB_CDEF_0F1E_2D3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_byte_valid = 0, ack;
  logic [7:0] ev_byte = 8'h00;
  logic pwr_on = 0, pll_hold = 1, cfg_load = 0, busy, done;
  logic [W-1:0] cfg_load_data = '0, cfg_q;
  logic [W-1:0] m_cfg, m_store;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  cfg_persist_seq #(.DEV_ADDR(DEV), .SAVE_CODE(CS), .RESTORE_CODE(CR),
    .SAVE_CYCLES(SC), .RESTORE_CYCLES(RC), .BOOT_CYCLES(BC), .STORE_INIT(INIT)) u_cfg_persist_seq (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte_valid(ev_byte_valid), .ev_byte(ev_byte), .ack(ack), .pwr_on(pwr_on),
    .pll_hold(pll_hold), .cfg_load(cfg_load), .cfg_load_data(cfg_load_data),
    .cfg_q(cfg_q), .busy(busy), .done(done));

  function automatic bit exp_go(input logic [6:0] a, input logic rw, input int nb,
                                input logic [7:0] code);
    return a == DEV && !rw && nb == 2 && (code == CS || code == CR)
           && pwr_on && !pll_hold && !m_cfg[57];
  endfunction
  function automatic int exp_len(input logic [7:0] code);
    return (code == CS) ? SC : RC;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic do_start();
    @(negedge clk) ev_start = 1;
    @(negedge clk) ev_start = 0;
  endtask
  task automatic do_stop();
    @(negedge clk) ev_stop = 1;
    @(negedge clk) ev_stop = 0;
  endtask
  task automatic do_byte(input logic [7:0] b, input logic exp, input string req);
    @(negedge clk) begin ev_byte = b; ev_byte_valid = 1; end
    #1 chk(ack == exp, req, W'(ack), W'(exp));
    @(negedge clk) ev_byte_valid = 0;
  endtask
  task automatic do_load(input logic [W-1:0] d);
    @(negedge clk) begin cfg_load = 1; cfg_load_data = d; end
    if (!busy) m_cfg = d;
    @(negedge clk) cfg_load = 0;
  endtask

  // sends one transfer, returns whether an operation is expected
  task automatic frame(input logic [6:0] a, input logic rw, input int nb,
                       input logic [7:0] code, output bit go);
    go = exp_go(a, rw, nb, code);
    do_start();
    do_byte({a, rw}, a == DEV, "R3 address ack");
    for (int i = 1; i < nb; i++)
      do_byte((i == 1) ? code : 8'($urandom), a == DEV && !rw, "R4 data ack");
    do_stop();
  endtask

  task automatic wait_end(input int exp_n, input bit measure, input logic [7:0] code);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    if (measure) chk(n == exp_n, "R5 busy length", W'(n), W'(exp_n));
    chk(done == 1'b1, "R7 done pulse", W'(done), W'(1));
    if (code == CS) m_store = m_cfg; else m_cfg = m_store;
    @(negedge clk) chk(done == 1'b0, "R7 done single", W'(done), W'(0));
    chk(cfg_q == m_cfg, "R7 cfg after op", cfg_q, m_cfg);
  endtask

  task automatic op(input logic [6:0] a, input logic rw, input int nb, input logic [7:0] code);
    bit go;
    frame(a, rw, nb, code, go);
    if (go) begin
      chk(busy == 1'b1, "R5 busy after stop", W'(busy), W'(1));
      wait_end(exp_len(code), 1'b1, code);
    end else begin
      chk(busy == 1'b0, "R8 R9 no op", W'(busy), W'(0));
      @(negedge clk) chk(busy == 1'b0 && done == 1'b0, "R9 still idle", W'({busy, done}), W'(0));
      chk(cfg_q == m_cfg, "R8 cfg unchanged", cfg_q, m_cfg);
    end
  endtask

  initial begin
    bit go;
    int n;
    logic [W-1:0] keep;
    void'($urandom(32'd4242));
    m_cfg = '0; m_store = INIT;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy at reset", W'(busy), W'(1));
    chk(cfg_q == '0, "R1 cfg zero", cfg_q, '0);
    do_start();
    do_byte({DEV, 1'b0}, 1'b0, "R6 no ack during boot");
    repeat (4) @(negedge clk);
    chk(busy == 1'b1 && cfg_q == '0, "R2 boot waits for power", W'(busy), W'(1));
    pwr_on = 1;   // pll_hold still high: boot ignores it (R2)
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == BC, "R2 boot length", W'(n), W'(BC));
    chk(done == 1'b1, "R1 boot done", W'(done), W'(1));
    chk(cfg_q == INIT, "R1 boot restore", cfg_q, INIT);
    m_cfg = INIT;
    @(negedge clk) chk(done == 1'b0, "R1 done single", W'(done), W'(0));
    pll_hold = 0;

    // R3 addresses
    op(DEV, 1'b1, 1, 8'h00);
    op(DEV ^ 7'h01, 1'b0, 2, CS);

    // R6 / R10 during a save
    keep = {$urandom, $urandom, $urandom};
    keep[57] = 1'b0;
    do_load(keep);
    frame(DEV, 1'b0, 2, CS, go);
    chk(busy == 1'b1, "R5 save started", W'(busy), W'(1));
    do_start();
    do_byte({DEV, 1'b0}, 1'b0, "R6 own address while busy");
    do_load({W{1'b1}});
    chk(cfg_q == keep, "R10 load ignored while busy", cfg_q, keep);
    wait_end(0, 1'b0, CS);
    op(DEV, 1'b1, 1, 8'h00);   // R11 address acked again

    do_load(~keep & ~(W'(1) << 57));
    op(DEV, 1'b0, 2, CR);        // R7 restore brings back keep
    chk(cfg_q == keep, "R7 restore value", cfg_q, keep);

    // R8 interlocks
    pll_hold = 1; op(DEV, 1'b0, 2, CR); pll_hold = 0;
    pwr_on = 0;   op(DEV, 1'b0, 2, CS); pwr_on = 1;
    do_load(keep | (W'(1) << 57));
    op(DEV, 1'b0, 2, CS);
    op(DEV, 1'b0, 2, CR);
    do_load(keep);
    op(DEV, 1'b0, 2, CR);        // store still keep after blocked save (R8)

    // R9 malformed transfers
    op(DEV, 1'b0, 2, 8'h33);
    op(DEV, 1'b0, 3, CS);
    op(DEV, 1'b0, 1, 8'h00);
    op(DEV, 1'b1, 2, CR);

    for (int it = 0; it < 60; it++) begin
      int sel = int'($urandom % 6);
      logic [W-1:0] d = {$urandom, $urandom, $urandom};
      pwr_on   = ($urandom % 8) != 0;
      pll_hold = ($urandom % 8) == 0;
      d[57]    = ($urandom % 6) == 0;
      case (sel)
        0: do_load(d);
        1: op(DEV, 1'b0, 2, ($urandom % 2) ? CS : CR);
        2: op(DEV, 1'b0, 2, CS);
        3: op(DEV, 1'b0, 2 + int'($urandom % 2), 8'($urandom));
        4: op(($urandom % 4) ? DEV : 7'($urandom), 1'b0, 2, CR);
        default: op(DEV, 1'($urandom), 1 + int'($urandom % 3), CS);
      endcase
    end
    finish_run();
  end
endmodule